// File: doc/BRIEF.md
# Byte-Serial Counter Host Port

This block is the host-side front end of one 24-bit counter channel. A host reaches it through two 8-bit ports selected by a single address line: a data port and a control/status port. The wide values go through the data port one byte at a time, least significant byte first. Writes build up the preset value and reads return the output latch. An internal byte pointer steps after every data-port access and can be sent back to byte 0 by command.

A write to the control port is one command word. Its three top bits select the target. Group 000 holds the one-shot commands: pointer reset, counter snapshot, preset-to-counter transfer and flag clears. Groups 001, 010 and 011 load the counting-mode, I/O and index configuration registers. A read of the control port returns the live flag byte from the counter core. The counter core itself is outside this block. It receives the preset value, the configuration fields and the one-cycle strobes.

The byte pointer is a three-state machine: `PTR_B0`, `PTR_B1` and `PTR_B2`. Transition ADVANCE (data-port read or write) moves B0 to B1, B1 to B2 and B2 to B0. Transition RESET (command 0x01 or 0x11) moves any state to B0 and takes priority over ADVANCE.

Top module: `cnt_host_port`

## Requirements
- R1: After reset the preset is 0, the output latch is 0, every configuration field is 0, all strobes are low and the byte pointer is at byte 0.
- R2: Each data-port write (bus_ctrl=0) stores bus_wdata into the preset byte at the pointer (byte 0 = bits 7:0, byte 2 = bits 23:16) and advances the pointer. After byte 2 it wraps to byte 0.
- R3: A data-port read returns the output-latch byte at the pointer on bus_rdata in the same cycle and advances the pointer, wrapping after byte 2. No other access moves the pointer except the reset commands.
- R4: Control word 0x01 returns the pointer to byte 0. Control word 0x11 returns the pointer to byte 0 and copies cnt_value into the output latch at that clock edge. The latch then holds that value while cnt_value changes.
- R5: Control word 0x08 raises load_cnt for exactly the one cycle after the write. While it is high, preset_val carries the value to transfer.
- R6: Control words 0x02 and 0x04 raise clr_flags for the one cycle after the write. Control word 0x06 raises clr_err for that cycle. Any other word in group 000 (for example 0x03) raises no strobe.
- R7: A control word 001xxxxx loads the mode register: bit 0 to cfg_binary, bits 2:1 to cfg_count_mode and bits 4:3 to cfg_quad_mode (00 = non-quadrature).
- R8: A control word 010xxxxx loads bit 0 to cfg_ab_en and bit 1 to cfg_continuous (1 = count continuously, 0 = preset on index).
- R9: A control word 011xxxxx loads bit 1 to cfg_idx_pol (1 = active high) and bit 0 to cfg_idx_sync.
- R10: While cfg_quad_mode is 00, a request for synchronous index mode is ignored and cfg_idx_sync stays 0. A mode write with bits 4:3 = 00 forces cfg_idx_sync to 0.
- R11: A control-port read returns {2'b00, st_up, st_noise, 2'b00, st_carry, st_borrow} and does not move the byte pointer.
- R12: A control word whose bit 7 is 1 changes no register, no preset byte and no pointer, and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ctrl | input | 1 | 0 = data port, 1 = control/status port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cnt_value | input | 24 | Live counter value from the core |
| st_borrow | input | 1 | Borrow flag from the core |
| st_carry | input | 1 | Carry flag from the core |
| st_noise | input | 1 | Excess-noise flag from the core |
| st_up | input | 1 | Count direction, 1 = up |
| preset_val | output | 24 | Preset register |
| load_cnt | output | 1 | One-cycle preset-to-counter transfer strobe |
| clr_flags | output | 1 | One-cycle borrow/carry/compare/sign clear strobe |
| clr_err | output | 1 | One-cycle error-flag clear strobe |
| cfg_binary | output | 1 | Binary counting select |
| cfg_count_mode | output | 2 | Count mode code |
| cfg_quad_mode | output | 2 | Quadrature mode code, 00 = non-quadrature |
| cfg_ab_en | output | 1 | A/B input enable |
| cfg_continuous | output | 1 | 1 = continuous count, 0 = preset on index |
| cfg_idx_sync | output | 1 | Synchronous index mode |
| cfg_idx_pol | output | 1 | Index polarity, 1 = active high |

## Verification
A byte pointer in the wrong state shows up on the very next data access. A read returns a neighbouring latch byte, or a write lands in the wrong third of preset_val. Both are visible within one cycle, so every pointer movement is checked with a following data access. Misdecoded command words show up one cycle after the write, as a wrong strobe or a configuration field that changed when it should not have. A synchronous-index bit left set under non-quadrature mode is visible directly on cfg_idx_sync after the write that should have cleared or refused it.

// File: rtl/cnt_host_pkg.sv
package cnt_host_pkg;

    // The pointer FSM has one state per byte, so the byte count is fixed here
    localparam int NUM_BYTES = 3;
    localparam int PTR_W     = 2;

    typedef enum logic [PTR_W-1:0] {
        PTR_B0 = 2'd0,
        PTR_B1 = 2'd1,
        PTR_B2 = 2'd2
    } ptr_e;

    localparam logic [2:0] GRP_CMD  = 3'b000;
    localparam logic [2:0] GRP_MODE = 3'b001;
    localparam logic [2:0] GRP_IO   = 3'b010;
    localparam logic [2:0] GRP_IDX  = 3'b011;

    localparam logic [7:0] OP_PTR_RST  = 8'h01;
    localparam logic [7:0] OP_CLR_A    = 8'h02;
    localparam logic [7:0] OP_CLR_B    = 8'h04;
    localparam logic [7:0] OP_CLR_ERR  = 8'h06;
    localparam logic [7:0] OP_LOAD     = 8'h08;
    localparam logic [7:0] OP_SNAP     = 8'h11;

    typedef struct packed {
        logic binary;
        logic [1:0] cmode;
        logic [1:0] qmode;
        logic ab_en;
        logic cont;
        logic sync;
        logic pol;
    } cfg_t;

    typedef struct packed {
        logic ptr_rst;
        logic snap;
        logic load;
        logic clr_flags;
        logic clr_err;
        logic wr_mode;
        logic wr_io;
        logic wr_idx;
    } cmd_t;

endpackage

// File: rtl/chp_byte_ptr.sv
module chp_byte_ptr
    import cnt_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             rst_ptr,
    output ptr_e             state,
    output logic [PTR_W-1:0] byte_idx
);

    ptr_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PTR_B0;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (rst_ptr) begin
            nxt = PTR_B0;
        end else if (adv) begin
            unique case (state)
                PTR_B0:  nxt = PTR_B1;
                PTR_B1:  nxt = PTR_B2;
                PTR_B2:  nxt = PTR_B0;
                default: nxt = PTR_B0;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            PTR_B0:  byte_idx = 2'd0;
            PTR_B1:  byte_idx = 2'd1;
            PTR_B2:  byte_idx = 2'd2;
            default: byte_idx = 2'd0;
        endcase
    end

endmodule

// File: rtl/chp_cmd_decode.sv
module chp_cmd_decode
    import cnt_host_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] word,
    output cmd_t              cmd
);

    logic [2:0] grp;
    assign grp = word[BYTE_W-1 -: 3];

    always_comb begin
        cmd = '0;
        if (ctrl_wr) begin
            case (grp)
                GRP_CMD: begin
                    case (word)
                        OP_PTR_RST: cmd.ptr_rst = 1'b1;
                        OP_SNAP: begin
                            cmd.ptr_rst = 1'b1;
                            cmd.snap    = 1'b1;
                        end
                        OP_LOAD:    cmd.load      = 1'b1;
                        OP_CLR_A:   cmd.clr_flags = 1'b1;
                        OP_CLR_B:   cmd.clr_flags = 1'b1;
                        OP_CLR_ERR: cmd.clr_err   = 1'b1;
                        default:    cmd = '0;
                    endcase
                end
                GRP_MODE: cmd.wr_mode = 1'b1;
                GRP_IO:   cmd.wr_io   = 1'b1;
                GRP_IDX:  cmd.wr_idx  = 1'b1;
                default:  cmd = '0;
            endcase
        end
    end

endmodule

// File: rtl/chp_cfg_regs.sv
module chp_cfg_regs
    import cnt_host_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd,
    input  logic [BYTE_W-1:0] word,
    output cfg_t              cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cmd.wr_mode) begin
            cfg.binary <= word[0];
            cfg.cmode  <= word[2:1];
            cfg.qmode  <= word[4:3];
            if (word[4:3] == 2'b00) cfg.sync <= 1'b0;
        end else if (cmd.wr_io) begin
            cfg.ab_en <= word[0];
            cfg.cont  <= word[1];
        end else if (cmd.wr_idx) begin
            cfg.pol <= word[1];
            if (cfg.qmode != 2'b00) cfg.sync <= word[0];
        end
    end

endmodule

// File: rtl/cnt_host_port.sv
module cnt_host_port
    import cnt_host_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int VAL_W = BYTE_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_ctrl,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [VAL_W-1:0]  cnt_value,
    input  logic              st_borrow,
    input  logic              st_carry,
    input  logic              st_noise,
    input  logic              st_up,
    output logic [VAL_W-1:0]  preset_val,
    output logic              load_cnt,
    output logic              clr_flags,
    output logic              clr_err,
    output logic              cfg_binary,
    output logic [1:0]        cfg_count_mode,
    output logic [1:0]        cfg_quad_mode,
    output logic              cfg_ab_en,
    output logic              cfg_continuous,
    output logic              cfg_idx_sync,
    output logic              cfg_idx_pol
);

    logic data_acc, data_wr, ctrl_wr;
    assign data_acc = bus_sel && !bus_ctrl;
    assign data_wr  = data_acc && bus_wr;
    assign ctrl_wr  = bus_sel && bus_ctrl && bus_wr;

    cmd_t             cmd;
    cfg_t             cfg;
    ptr_e             ptr_st;
    logic [PTR_W-1:0] byte_idx;
    logic [VAL_W-1:0] latch_q;

    chp_cmd_decode #(.BYTE_W(BYTE_W)) u_dec (
        .ctrl_wr (ctrl_wr),
        .word    (bus_wdata),
        .cmd     (cmd)
    );

    chp_byte_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (data_acc),
        .rst_ptr  (cmd.ptr_rst),
        .state    (ptr_st),
        .byte_idx (byte_idx)
    );

    chp_cfg_regs #(.BYTE_W(BYTE_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .word  (bus_wdata),
        .cfg   (cfg)
    );

    // Preset bytes, one register per byte lane
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_preset
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_q <= '0;
            else if (data_wr && byte_idx == PTR_W'(i))
                lane_q <= bus_wdata;
        end
        assign preset_val[i*BYTE_W +: BYTE_W] = lane_q;
    end

    // Output latch snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        latch_q <= '0;
        else if (cmd.snap) latch_q <= cnt_value;
    end

    // One-cycle command strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_cnt  <= 1'b0;
            clr_flags <= 1'b0;
            clr_err   <= 1'b0;
        end else begin
            load_cnt  <= cmd.load;
            clr_flags <= cmd.clr_flags;
            clr_err   <= cmd.clr_err;
        end
    end

    logic [BYTE_W-1:0] status_b;
    always_comb begin
        status_b    = '0;
        status_b[0] = st_borrow;
        status_b[1] = st_carry;
        status_b[4] = st_noise;
        status_b[5] = st_up;
    end

    assign bus_rdata = bus_ctrl ? status_b
                                : latch_q[int'(byte_idx)*BYTE_W +: BYTE_W];

    assign cfg_binary     = cfg.binary;
    assign cfg_count_mode = cfg.cmode;
    assign cfg_quad_mode  = cfg.qmode;
    assign cfg_ab_en      = cfg.ab_en;
    assign cfg_continuous = cfg.cont;
    assign cfg_idx_sync   = cfg.sync;
    assign cfg_idx_pol    = cfg.pol;

endmodule

// File: rtl/cnt_host_port_chk.sv
module cnt_host_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic       bus_ctrl,
    input logic [7:0] bus_wdata,
    input logic [1:0] ptr,
    input logic       load_cnt,
    input logic       clr_flags,
    input logic       clr_err,
    input logic [8:0] cfg_bits,
    input logic [1:0] cfg_quad_mode,
    input logic       cfg_idx_sync
);

    logic data_acc, ctrl_wr, ptr_cmd;
    assign data_acc = bus_sel && !bus_ctrl;
    assign ctrl_wr  = bus_sel && bus_ctrl && bus_wr;
    assign ptr_cmd  = ctrl_wr && (bus_wdata == 8'h01 || bus_wdata == 8'h11);

    // R2
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && ptr == 2'd2) |=> ptr == 2'd0);

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_acc && !ptr_cmd) |=> $stable(ptr));

    // R4
    ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_cmd |=> ptr == 2'd0);

    // R5
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata == 8'h08) |=> (load_cnt && !clr_flags && !clr_err));

    // R10
    sync_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_idx_sync |-> cfg_quad_mode != 2'b00);

    // R12
    upper_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[7]) |=> ($stable(cfg_bits) && $stable(ptr)
                                       && !load_cnt && !clr_flags && !clr_err));

endmodule

bind cnt_host_port cnt_host_port_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_ctrl      (bus_ctrl),
    .bus_wdata     (bus_wdata),
    .ptr           (byte_idx),
    .load_cnt      (load_cnt),
    .clr_flags     (clr_flags),
    .clr_err       (clr_err),
    .cfg_bits      ({cfg_binary, cfg_count_mode, cfg_quad_mode, cfg_ab_en,
                     cfg_continuous, cfg_idx_sync, cfg_idx_pol}),
    .cfg_quad_mode (cfg_quad_mode),
    .cfg_idx_sync  (cfg_idx_sync)
);

// File: tb/cnt_host_port_test.sv
module cnt_host_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_ctrl = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] cnt_value = '0;
    logic        st_borrow = 1'b0, st_carry = 1'b0, st_noise = 1'b0, st_up = 1'b0;
    logic [23:0] preset_val;
    logic        load_cnt, clr_flags, clr_err;
    logic        cfg_binary, cfg_ab_en, cfg_continuous, cfg_idx_sync, cfg_idx_pol;
    logic [1:0]  cfg_count_mode, cfg_quad_mode;

    always #5 clk = ~clk;

    cnt_host_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_ctrl(bus_ctrl), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_value(cnt_value), .st_borrow(st_borrow), .st_carry(st_carry),
        .st_noise(st_noise), .st_up(st_up), .preset_val(preset_val),
        .load_cnt(load_cnt), .clr_flags(clr_flags), .clr_err(clr_err),
        .cfg_binary(cfg_binary), .cfg_count_mode(cfg_count_mode),
        .cfg_quad_mode(cfg_quad_mode), .cfg_ab_en(cfg_ab_en),
        .cfg_continuous(cfg_continuous), .cfg_idx_sync(cfg_idx_sync),
        .cfg_idx_pol(cfg_idx_pol)
    );

    // Observation selectors
    localparam int SEL_RDATA  = 0;
    localparam int SEL_PRESET = 1;
    localparam int SEL_CFG    = 2;
    localparam int SEL_STROBE = 3;

    typedef struct {
        int          sel;
        logic [23:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int fails = 0;
    bit done = 0;

    // Monitor: compares every pending expectation away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [23:0] obs;
            it = q.pop_front();
            case (it.sel)
                SEL_RDATA:  obs = {16'h0, bus_rdata};
                SEL_PRESET: obs = preset_val;
                SEL_CFG:    obs = {15'h0, cfg_binary, cfg_count_mode, cfg_quad_mode,
                                   cfg_ab_en, cfg_continuous, cfg_idx_sync, cfg_idx_pol};
                default:    obs = {21'h0, load_cnt, clr_flags, clr_err};
            endcase
            total++;
            if (obs !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, obs, it.exp);
            end
        end
    end

    function automatic logic [23:0] cfgv(logic b, logic [1:0] cm, logic [1:0] qm,
                                         logic ab, logic ct, logic sy, logic po);
        return {15'h0, b, cm, qm, ab, ct, sy, po};
    endfunction

    // Expectation for the current cycle, then move to the next cycle
    task automatic expect_now(int sel, logic [23:0] v, string tag);
        item_t it;
        it.sel = sel; it.exp = v; it.tag = tag;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic wr(logic ctrl, logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_ctrl = ctrl; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic ctrl, logic [7:0] e, string tag);
        item_t it;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_ctrl = ctrl;
        it.sel = SEL_RDATA; it.exp = {16'h0, e}; it.tag = tag;
        q.push_back(it);
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        expect_now(SEL_CFG, cfgv(0, 0, 0, 0, 0, 0, 0), "R1 cfg after reset");
        expect_now(SEL_PRESET, 24'h0, "R1 preset after reset");
        expect_now(SEL_STROBE, 24'h0, "R1 strobes after reset");
        rd(1'b0, 8'h00, "R1 latch byte0 after reset");
        wr(1'b1, 8'h01);

        // R2 preset bytes LSB first, then wrap
        wr(1'b0, 8'h56); wr(1'b0, 8'h34); wr(1'b0, 8'h12);
        expect_now(SEL_PRESET, 24'h123456, "R2 three-byte preset load");
        wr(1'b0, 8'hAB);
        expect_now(SEL_PRESET, 24'h1234AB, "R2 pointer wraps to byte0");

        // R4 pointer reset mid-sequence
        wr(1'b0, 8'hCD);
        wr(1'b1, 8'h01);
        wr(1'b0, 8'hEF);
        expect_now(SEL_PRESET, 24'h12CDEF, "R4 0x01 returns pointer to byte0");

        // R4 snapshot, R3 reads LSB first with wrap
        cnt_value = 24'hA1B2C3;
        wr(1'b1, 8'h11);
        cnt_value = 24'h0F0F0F;
        rd(1'b0, 8'hC3, "R3 latch byte0");
        rd(1'b0, 8'hB2, "R3 latch byte1");
        rd(1'b0, 8'hA1, "R3 latch byte2");
        rd(1'b0, 8'hC3, "R3 read pointer wraps");
        wr(1'b1, 8'h01);
        rd(1'b0, 8'hC3, "R4 latch holds snapshot after counter moves");

        // R5 / R6 strobes
        wr(1'b1, 8'h08);
        expect_now(SEL_STROBE, 24'h4, "R5 load strobe");
        expect_now(SEL_STROBE, 24'h0, "R5 load strobe lasts one cycle");
        wr(1'b1, 8'h02);
        expect_now(SEL_STROBE, 24'h2, "R6 clear flags on 0x02");
        wr(1'b1, 8'h04);
        expect_now(SEL_STROBE, 24'h2, "R6 clear flags on 0x04");
        wr(1'b1, 8'h06);
        expect_now(SEL_STROBE, 24'h1, "R6 clear error on 0x06");
        wr(1'b1, 8'h03);
        expect_now(SEL_STROBE, 24'h0, "R6 unlisted code raises nothing");

        // R7..R10 configuration
        wr(1'b1, 8'h3D);
        expect_now(SEL_CFG, cfgv(1, 2'b10, 2'b11, 0, 0, 0, 0), "R7 mode register fields");
        wr(1'b1, 8'h43);
        expect_now(SEL_CFG, cfgv(1, 2'b10, 2'b11, 1, 1, 0, 0), "R8 io control fields");
        wr(1'b1, 8'h63);
        expect_now(SEL_CFG, cfgv(1, 2'b10, 2'b11, 1, 1, 1, 1), "R9 index control fields");
        wr(1'b1, 8'h22);
        expect_now(SEL_CFG, cfgv(0, 2'b01, 2'b00, 1, 1, 0, 1), "R10 non-quadrature clears sync");
        wr(1'b1, 8'h61);
        expect_now(SEL_CFG, cfgv(0, 2'b01, 2'b00, 1, 1, 0, 0), "R10 sync request ignored");

        // R11 status byte and pointer hold
        st_borrow = 1'b1; st_up = 1'b1;
        rd(1'b1, 8'h21, "R11 status borrow and up");
        st_borrow = 1'b0; st_up = 1'b0; st_carry = 1'b1; st_noise = 1'b1;
        wr(1'b1, 8'h01);
        rd(1'b1, 8'h12, "R11 status carry and noise");
        rd(1'b0, 8'hC3, "R11 status read leaves pointer at byte0");

        // R12 upper group ignored
        wr(1'b1, 8'h9F);
        expect_now(SEL_STROBE, 24'h0, "R12 no strobe on upper group");
        wr(1'b1, 8'hFF);
        expect_now(SEL_CFG, cfgv(0, 2'b01, 2'b00, 1, 1, 0, 0), "R12 cfg unchanged");
        rd(1'b0, 8'hB2, "R12 pointer unchanged");
        expect_now(SEL_PRESET, 24'h12CDEF, "R12 preset unchanged");

        @(negedge clk); #1;
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule